// File: doc/BRIEF.md
# Windowed Key-Refresh Watchdog Timer

This block is a watchdog for a slow, always-on clock. A 16-bit counter counts down from a programmable load value. A prescaler sits in front of it and can insert an extra halving stage. Software keeps the timer alive by writing a fixed key to a refresh address. Any other value written there is treated as a fault. An optional lower window also treats a correct key as a fault if it arrives while the counter is still above a programmed minimum.

When the counter runs out, or a refresh fails, the block raises one event and reloads the counter. The event appears as a one-cycle reset request, or as a one-cycle interrupt pulse plus a pending flag, depending on the selected mode. Setting the enable bit locks the configuration. Only the block's reset releases the lock.

A halt input (for debug) and a hibernate-off input freeze the count. The current count is driven out so that the surrounding logic can observe it.

Top module: `wdog_window_top`

## Requirements
- R1: After reset the count reads 0x1000 and all outputs are low. The timer starts disabled, with the tick divide at 256 and reset requests allowed.
- R2: While enabled and not frozen, the count falls by one per tick. Control bits 3:2 set the tick period: 00=1, 01=16, 10=256 or 11=4096 clock cycles. Control bit 8 doubles that period.
- R3: A tick taken when the count is 1 or 0 produces one event. In the same cycle the counter reloads from the load register.
- R4: Writing 0xCCCC to address 3 while enabled and inside the window reloads the count from the load register. It also restarts the prescaler and produces no event.
- R5: Writing any other value to address 3 while enabled produces an event at once.
- R6: With control bit 9 set, a 0xCCCC write made while the count is above the minimum-load register (address 1) produces an event. A write with the count at or below the minimum is a valid refresh.
- R7: With control bit 1 set, an event gives a one-cycle pulse on `irq_pulse_o` and sets `irq_pend_o`, and no reset request is made. `irq_pend_o` stays set until a valid refresh. With bit 1 clear, an event pulses `rst_pulse_o` only if control bit 0 is set.
- R8: Once control bit 6 (enable) is set, writes to addresses 0, 1 and 2 have no effect until `rst_n` is asserted.
- R9: While disabled, addresses 0 to 2 are writable and the count follows the load register (address 0). Writes to address 3 are ignored.
- R10: While `halt_i` or `hib_off_i` is high, neither the count nor the prescaler advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock (low-frequency domain) |
| rst_n | input | 1 | Synchronous active-low reset; clears the lock |
| halt_i | input | 1 | Debug halt: freezes the count |
| hib_off_i | input | 1 | Hibernate disable: freezes the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 load, 1 minimum load, 2 control, 3 refresh |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| rst_pulse_o | output | 1 | One-cycle reset request |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |
| irq_pend_o | output | 1 | Interrupt pending until a valid refresh |

## Verification
The embedded assertions check the following on every cycle:
- The count steps down by exactly one per tick, and holds when there is no tick and no refresh write.
- An expiry always reloads the load value.
- The two event pulses are never high together, and the pending flag rises only with an interrupt pulse.
- A locked configuration never changes.
- A disabled timer never raises an event.

Some behaviour can only be shown by the bench's scenarios:
- The actual tick period for each divider setting.
- The exact window boundary, where a count equal to the minimum passes and one above it fails.
- The reset-enable bit being ignored in interrupt mode.
- Key writes being ignored while the timer is disabled.
- Only a reset releasing the lock.

// File: rtl/wdog_pkg.sv
// Package: shared constants and the decoded control type for the watchdog.
// Assumes a 16-bit refresh key and a two-bit register address.
package wdog_pkg;

    localparam logic [15:0] REFRESH_KEY = 16'hCCCC;

    typedef enum logic [1:0] {
        A_LOAD  = 2'd0,
        A_MIN   = 2'd1,
        A_CTRL  = 2'd2,
        A_CLEAR = 2'd3
    } addr_e;

    // Control word bit positions
    localparam int B_RSTEN = 0;
    localparam int B_IRQ   = 1;
    localparam int B_PSEL  = 2;
    localparam int B_EN    = 6;
    localparam int B_DIV2  = 8;
    localparam int B_WIN   = 9;

    typedef struct packed {
        logic       win;
        logic       div2;
        logic       en;
        logic [1:0] psel;
        logic       irq_mode;
        logic       rst_en;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{win: 1'b0, div2: 1'b0, en: 1'b0,
                                     psel: 2'b10, irq_mode: 1'b0, rst_en: 1'b1};

endpackage

// File: rtl/wdog_cfg_regs.sv
// Configuration registers: load, minimum load and control, plus refresh strobe.
// Assumes writes are single-cycle strobes; once enabled the config is frozen
// until rst_n, which is the only way to clear the lock.
module wdog_cfg_regs
    import wdog_pkg::*;
#(
    parameter int                CNT_W    = 16,
    parameter logic [CNT_W-1:0]  DEF_LOAD = 16'h1000,
    parameter logic [CNT_W-1:0]  DEF_MIN  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] min_o,
    output cfg_t             cfg_o,
    output logic             clr_stb_o,
    output logic [CNT_W-1:0] clr_data_o
);

    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] min_q;
    cfg_t             cfg_q;
    logic             cfg_wr;

    // Config writes are accepted only while the timer is not enabled
    assign cfg_wr = wr_en_i && !cfg_q.en;

    // Register update with lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= DEF_LOAD;
            min_q  <= DEF_MIN;
            cfg_q  <= CFG_DEFAULT;
        end else if (cfg_wr) begin
            case (wr_addr_i)
                A_LOAD: load_q <= wr_data_i;
                A_MIN:  min_q  <= wr_data_i;
                A_CTRL: begin
                    cfg_q.rst_en   <= wr_data_i[B_RSTEN];
                    cfg_q.irq_mode <= wr_data_i[B_IRQ];
                    cfg_q.psel     <= wr_data_i[B_PSEL+1:B_PSEL];
                    cfg_q.en       <= wr_data_i[B_EN];
                    cfg_q.div2     <= wr_data_i[B_DIV2];
                    cfg_q.win      <= wr_data_i[B_WIN];
                end
                default: ;
            endcase
        end
    end

    assign load_o     = load_q;
    assign min_o      = min_q;
    assign cfg_o      = cfg_q;
    assign clr_stb_o  = wr_en_i && (wr_addr_i == A_CLEAR);
    assign clr_data_o = wr_data_i;

    // R8: an enabled configuration never changes before reset
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.en |=> cfg_q.en && $stable(load_q) && $stable(min_q) && $stable(cfg_q));

endmodule

// File: rtl/wdog_prescaler.sv
// Tick prescaler: one tick every 2^(psel*STEP + div2) running cycles.
// Assumes psel/div2 are stable while running (locked config); restart zeroes it.
module wdog_prescaler #(
    parameter int PSEL_W = 2,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              div2_i,
    output logic              tick_o
);

    localparam int PRE_W = STEP * ((1 << PSEL_W) - 1) + 1;
    localparam int SH_W  = $clog2(PRE_W + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic [SH_W-1:0]  shift;

    // Terminal value of the prescaler for the selected divide
    always_comb begin
        shift = SH_W'(psel_i) * SH_W'(STEP) + SH_W'(div2_i);
        lim   = (PRE_W'(1) << shift) - PRE_W'(1);
    end

    assign tick_o = run_i && (pre_q == lim);

    // Prescaler count, frozen when not running
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (restart_i)  pre_q <= '0;
        else if (tick_o)     pre_q <= '0;
        else if (run_i)      pre_q <= pre_q + PRE_W'(1);
    end

    // R2: the running prescaler never passes its terminal value
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> pre_q <= lim);

    // R10: a stopped prescaler keeps its value
    a_r10_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !restart_i |=> $stable(pre_q));

endmodule

// File: rtl/wdog_core.sv
// Watchdog counter and event logic: countdown, key check, window check,
// reload and the reset/interrupt outputs. Assumes tick_i only when enabled.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] DEF_LOAD = 16'h1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] min_i,
    input  logic             tick_i,
    input  logic             clr_stb_i,
    input  logic [CNT_W-1:0] clr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             restart_o,
    output logic             rst_pulse_o,
    output logic             irq_pulse_o,
    output logic             irq_pend_o
);

    logic [CNT_W-1:0] count_q;
    logic             clr_act;
    logic             too_early;
    logic             refresh_ok;
    logic             bad_clear;
    logic             expire;
    logic             event_w;

    // Refresh qualification and event selection
    always_comb begin
        clr_act    = clr_stb_i && cfg_i.en;
        too_early  = cfg_i.win && (count_q > min_i);
        refresh_ok = clr_act && (clr_data_i == CNT_W'(REFRESH_KEY)) && !too_early;
        bad_clear  = clr_act && !refresh_ok;
        expire     = tick_i && (count_q <= CNT_W'(1)) && !clr_act;
        event_w    = bad_clear || expire;
    end

    assign restart_o = refresh_ok || event_w || !cfg_i.en;

    // Counter: follow load when disabled, reload on refresh/event, else count
    always_ff @(posedge clk) begin
        if (!rst_n)                     count_q <= DEF_LOAD;
        else if (!cfg_i.en)             count_q <= load_i;
        else if (refresh_ok || event_w) count_q <= load_i;
        else if (tick_i)                count_q <= count_q - CNT_W'(1);
    end

    // Event outputs and interrupt pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse_o <= 1'b0;
            irq_pulse_o <= 1'b0;
            irq_pend_o  <= 1'b0;
        end else begin
            rst_pulse_o <= event_w && !cfg_i.irq_mode && cfg_i.rst_en;
            irq_pulse_o <= event_w && cfg_i.irq_mode;
            if (refresh_ok)                     irq_pend_o <= 1'b0;
            else if (event_w && cfg_i.irq_mode) irq_pend_o <= 1'b1;
        end
    end

    assign count_o = count_q;

    // R2: one step down per tick away from expiry
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && (count_q > CNT_W'(1)) && !clr_stb_i |=> count_q == $past(count_q) - CNT_W'(1));

    // R3: expiry reloads the load value
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && (count_q <= CNT_W'(1)) && !clr_stb_i |=> count_q == $past(load_i));

    // R10: no tick and no refresh write means the count holds
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.en && !tick_i && !clr_stb_i |=> $stable(count_q));

    // R7: reset request and interrupt pulse are exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_pulse_o, irq_pulse_o}));

    // R7: pending rises only with an interrupt pulse
    a_r7_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend_o) |-> irq_pulse_o);

    // R9: a disabled timer never raises an event
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> !rst_pulse_o && !irq_pulse_o);

endmodule

// File: rtl/wdog_window_top.sv
// Top of the windowed watchdog: config registers, prescaler and counter core.
// Assumes all logic runs on the low-frequency watchdog clock.
module wdog_window_top
    import wdog_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               PSEL_W   = 2,
    parameter int               STEP     = 4,
    parameter logic [CNT_W-1:0] DEF_LOAD = 16'h1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             hib_off_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_pulse_o,
    output logic             irq_pulse_o,
    output logic             irq_pend_o
);

    cfg_t             cfg;
    logic [CNT_W-1:0] load_v;
    logic [CNT_W-1:0] min_v;
    logic             clr_stb;
    logic [CNT_W-1:0] clr_data;
    logic             tick;
    logic             restart;
    logic             run;

    assign run = cfg.en && !halt_i && !hib_off_i;

    wdog_cfg_regs #(.CNT_W(CNT_W), .DEF_LOAD(DEF_LOAD), .DEF_MIN('0)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .load_o     (load_v),
        .min_o      (min_v),
        .cfg_o      (cfg),
        .clr_stb_o  (clr_stb),
        .clr_data_o (clr_data)
    );

    wdog_prescaler #(.PSEL_W(PSEL_W), .STEP(STEP)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .psel_i    (cfg.psel),
        .div2_i    (cfg.div2),
        .tick_o    (tick)
    );

    wdog_core #(.CNT_W(CNT_W), .DEF_LOAD(DEF_LOAD)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .load_i      (load_v),
        .min_i       (min_v),
        .tick_i      (tick),
        .clr_stb_i   (clr_stb),
        .clr_data_i  (clr_data),
        .count_o     (count_o),
        .restart_o   (restart),
        .rst_pulse_o (rst_pulse_o),
        .irq_pulse_o (irq_pulse_o),
        .irq_pend_o  (irq_pend_o)
    );

endmodule

// File: tb/test_wdog_window_top.sv
`timescale 1ns/1ps
module test_wdog_window_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_i = 1'b0;
    logic        hib_off_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = 2'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic [15:0] count_o;
    logic        rst_pulse_o;
    logic        irq_pulse_o;
    logic        irq_pend_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdog_window_top i_wdog_window_top (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .hib_off_i(hib_off_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .count_o(count_o), .rst_pulse_o(rst_pulse_o),
        .irq_pulse_o(irq_pulse_o), .irq_pend_o(irq_pend_o)
    );

    typedef struct packed {
        logic [15:0] minv;
        logic [15:0] ctrl;
        logic [15:0] wt;
        logic [15:0] data;
        logic        e_rst;
        logic        e_irq;
    } vec_t;

    // Load is 0x40 and the divide is 1, so the count at the key write is 0x40 - wt
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h0041, 16'd10, 16'hCCCC, 1'b0, 1'b0},
        '{16'h0000, 16'h0041, 16'd10, 16'h1234, 1'b1, 1'b0},
        '{16'h0020, 16'h0241, 16'd10, 16'hCCCC, 1'b1, 1'b0},
        '{16'h0020, 16'h0241, 16'd40, 16'hCCCC, 1'b0, 1'b0},
        '{16'h0020, 16'h0241, 16'd32, 16'hCCCC, 1'b0, 1'b0},
        '{16'h0020, 16'h0241, 16'd31, 16'hCCCC, 1'b1, 1'b0},
        '{16'h0000, 16'h0043, 16'd5,  16'h0000, 1'b0, 1'b1},
        '{16'h0000, 16'h0042, 16'd5,  16'hABCD, 1'b0, 1'b1},
        '{16'h0000, 16'h0040, 16'd5,  16'h5555, 1'b0, 1'b0},
        '{16'h0020, 16'h0243, 16'd10, 16'hCCCC, 1'b0, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; halt_i = 1'b0; hib_off_i = 1'b0; wr_en_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [15:0] ld, input logic [15:0] mn, input logic [15:0] ct);
        wr(2'd0, ld); wr(2'd1, mn); wr(2'd2, ct);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", "count", count_o, 32'h1000);
        chk("R1", "rst", rst_pulse_o, 0);
        chk("R1", "irq", irq_pulse_o, 0);
        chk("R1", "pend", irq_pend_o, 0);

        // Vector walk: refresh outcomes (R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            string rq;
            do_reset();
            setup(16'h0040, VECS[i].minv, VECS[i].ctrl);
            repeat (int'(VECS[i].wt)) step();
            wr(2'd3, VECS[i].data);
            if (VECS[i].ctrl[9])           rq = "R6";
            else if (VECS[i].ctrl[1])      rq = "R7";
            else if (VECS[i].data != 16'hCCCC) rq = "R5";
            else                            rq = "R4";
            chk(rq, $sformatf("vec%0d rst", i), rst_pulse_o, VECS[i].e_rst);
            chk(rq, $sformatf("vec%0d irq", i), irq_pulse_o, VECS[i].e_irq);
            chk("R4", $sformatf("vec%0d reload", i), count_o, 32'h40);
        end

        // R3 expiry with reset request
        do_reset();
        setup(16'h0008, 16'h0, 16'h0041);
        repeat (7) step();
        chk("R3", "count before expiry", count_o, 1);
        step();
        chk("R3", "rst pulse", rst_pulse_o, 1);
        chk("R3", "reload", count_o, 8);
        step();
        chk("R3", "pulse width", rst_pulse_o, 0);
        chk("R3", "count after", count_o, 7);

        // R7 interrupt pending until valid refresh
        do_reset();
        setup(16'h0008, 16'h0, 16'h0042);
        repeat (8) step();
        chk("R7", "irq pulse", irq_pulse_o, 1);
        chk("R7", "no rst", rst_pulse_o, 0);
        chk("R7", "pend set", irq_pend_o, 1);
        step();
        chk("R7", "irq width", irq_pulse_o, 0);
        chk("R7", "pend held", irq_pend_o, 1);
        wr(2'd3, 16'hCCCC);
        chk("R7", "pend cleared", irq_pend_o, 0);

        // R8 lock
        do_reset();
        setup(16'h0040, 16'h0, 16'h0041);
        wr(2'd0, 16'h0005);
        wr(2'd2, 16'h0000);
        chk("R8", "still running", count_o, 32'h3E);
        wr(2'd3, 16'hCCCC);
        chk("R8", "load kept", count_o, 32'h40);
        do_reset();
        wr(2'd0, 16'h0005);
        step();
        chk("R8", "unlocked by reset", count_o, 5);

        // R9 disabled behaviour
        do_reset();
        wr(2'd0, 16'h0123);
        step();
        chk("R9", "count follows load", count_o, 32'h123);
        wr(2'd3, 16'h1111);
        chk("R9", "clear ignored rst", rst_pulse_o, 0);
        repeat (20) step();
        chk("R9", "no counting", count_o, 32'h123);
        wr(2'd2, 16'h000D);
        wr(2'd2, 16'h0041);
        step();
        chk("R9", "ctrl writable", count_o, 32'h122);

        // R2 tick periods
        for (int k = 0; k < 5; k++) begin
            int ps;
            int d2;
            int per;
            ps = (k == 0) ? 0 : (k <= 2) ? 1 : k - 1;
            d2 = (k == 0 || k == 2) ? 1 : 0;
            per = 1 << (4 * ps + d2);
            do_reset();
            setup(16'h0040, 16'h0, 16'(16'h0041 | (ps << 2) | (d2 << 8)));
            repeat (per - 1) step();
            chk("R2", $sformatf("hold ps%0d d%0d", ps, d2), count_o, 32'h40);
            step();
            chk("R2", $sformatf("step ps%0d d%0d", ps, d2), count_o, 32'h3F);
        end

        // R4 refresh restarts the prescaler
        do_reset();
        setup(16'h0040, 16'h0, 16'h0045);
        repeat (10) step();
        wr(2'd3, 16'hCCCC);
        repeat (15) step();
        chk("R4", "prescaler restarted", count_o, 32'h40);
        step();
        chk("R4", "first tick after refresh", count_o, 32'h3F);

        // R10 halt and hibernate freeze
        do_reset();
        setup(16'h0040, 16'h0, 16'h0041);
        repeat (5) step();
        halt_i = 1'b1;
        repeat (10) step();
        chk("R10", "halt freeze", count_o, 32'h3B);
        halt_i = 1'b0;
        step();
        chk("R10", "resume", count_o, 32'h3A);
        hib_off_i = 1'b1;
        repeat (4) step();
        chk("R10", "hib freeze", count_o, 32'h3A);
        hib_off_i = 1'b0;
        step();
        chk("R10", "hib resume", count_o, 32'h39);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule